// File: doc/BRIEF.md
# Mixed-Precision Operand Pair Scheduler

This block sits in front of a lane-reconfigurable multiplier array that can run one wide product, two half-width products or four quarter-width products per pass. It accepts a stream of operand pairs of mixed magnitude. For each pair it finds the narrowest precision class that holds both operands. It packs pairs of the same class side by side into shared lane patterns, so that one buffer word carries one, two or four pairs. Each accepted pair lands in the open pattern of its class. A new pattern slot is claimed in the buffer only when that class has no open pattern.

A fill ends when every buffer slot has been claimed, or when a flush arrives with at least one pattern claimed. The block then stops taking input and drains the buffer one pattern per cycle. It sends all narrow patterns first, then all half-width patterns, then all wide patterns, so the supply setting changes at most twice per buffer. Each emitted pattern carries its lane mode, its lane-valid mask and the voltage and frequency codes for its class, read from a small table that software loads after characterisation. Per-class pattern counts for the current fill are visible on dedicated outputs.

Top module: `mpsched_top`

## Requirements
- R1: An operand is class 0 (narrow) when its bits above bit 7 are all zero, class 1 (half) when bits 31:16 are zero but some bit in 15:8 is set, and class 2 (wide) otherwise. A pair takes the larger class of its two operands, and `out_mode` carries that class code.
- R2: Lane k of a class c pattern occupies bits [k*W +: W] of `out_a` and `out_b`, with W = 8, 16 or 32 for c = 0, 1, 2. Lanes are filled in arrival order from lane 0, and each operand is truncated to W bits.
- R3: `out_mask` bit k is set exactly when lane k holds a pair. Unfilled lanes of a padded pattern read as zero in both words.
- R4: Input stays ready while fewer than 60 pattern slots are claimed. The accept that claims the 60th slot closes the fill, and draining starts on the next cycle.
- R5: A flush closes the fill when a slot is claimed or a pair is accepted in the same cycle. A flush on an empty buffer leaves `in_ready` high and `out_valid` low.
- R6: The drain emits one pattern on every cycle with no gaps, in class order 0, 1, 2, and within a class in slot-claim order.
- R7: `in_ready` is low on every drain cycle and returns high on the cycle after the last pattern.
- R8: `n8_cnt`, `n16_cnt` and `n32_cnt` give the number of patterns claimed per class in the current fill, and they return to zero when the drain ends.
- R9: `out_volt` and `out_freq` come from the table entry of `out_mode`. After reset every voltage code is 63, and the frequency codes are 8, 4 and 2 for classes 2, 1 and 0.
- R10: A table write with `cfg_sel` 0, 1 or 2 replaces that class entry from the next cycle onward. A write with `cfg_sel` 3 changes no entry.
- R11: After reset `in_ready` is high, `out_valid` is low and all counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Pair accepted this cycle when high with in_valid |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Second operand |
| flush | input | 1 | Close the current fill early |
| out_valid | output | 1 | A pattern is presented this cycle |
| out_a | output | 32 | Packed first-operand lanes |
| out_b | output | 32 | Packed second-operand lanes |
| out_mask | output | 4 | Lane-valid mask |
| out_mode | output | 2 | Lane mode (class code) |
| out_volt | output | 6 | Voltage code for the mode |
| out_freq | output | 4 | Frequency code for the mode |
| n8_cnt | output | 6 | Narrow patterns in the current fill |
| n16_cnt | output | 6 | Half-width patterns in the current fill |
| n32_cnt | output | 6 | Wide patterns in the current fill |
| cfg_we | input | 1 | Table write strobe |
| cfg_sel | input | 2 | Table entry select |
| cfg_volt | input | 6 | Voltage code to write |
| cfg_freq | input | 4 | Frequency code to write |

## Verification
The edge that accepts the closing pair or the flush is followed directly by the first drained pattern, because the outputs are combinational from registered state. The bench therefore drives on a falling edge, lets one rising edge pass, and samples every following falling edge once per expected pattern. The edge after the last pattern must show `out_valid` low and `in_ready` high. Counts are compared on the first drain cycle. A table write is sampled only in drains that begin after the write edge.

// File: rtl/mps_pkg.sv
package mps_pkg;
   typedef enum logic [1:0] {
      CLS_N8  = 2'd0,
      CLS_N16 = 2'd1,
      CLS_N32 = 2'd2
   } prec_e;

   typedef enum logic {
      PH_FILL  = 1'b0,
      PH_DRAIN = 1'b1
   } phase_e;
endpackage

// File: rtl/mps_classify.sv
module mps_classify
   import mps_pkg::*;
#(
   parameter int SUBW = 8
) (
   input  logic [4*SUBW-1:0] opa,
   input  logic [4*SUBW-1:0] opb,
   output prec_e             cls
);
   localparam int OPW = 4 * SUBW;

   function automatic prec_e span_of(input logic [OPW-1:0] v);
      if (|v[OPW-1:2*SUBW])
         return CLS_N32;
      else if (|v[2*SUBW-1:SUBW])
         return CLS_N16;
      return CLS_N8;
   endfunction

   prec_e ca, cb;

   always_comb begin
      ca  = span_of(opa);
      cb  = span_of(opb);
      cls = (ca > cb) ? ca : cb;
   end
endmodule

// File: rtl/mps_store.sv
module mps_store
   import mps_pkg::*;
#(
   parameter int SUBW  = 8,
   parameter int DEPTH = 60,
   localparam int OPW  = 4 * SUBW,
   localparam int AW   = $clog2(DEPTH),
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  prec_e            wr_cls,
   input  logic [OPW-1:0]   wr_a,
   input  logic [OPW-1:0]   wr_b,
   input  logic             pop_en,
   input  logic [AW-1:0]    pop_idx,
   input  logic             clear,
   output logic [DEPTH-1:0] pend_n8,
   output logic [DEPTH-1:0] pend_n16,
   output logic [DEPTH-1:0] pend_n32,
   output logic [OPW-1:0]   rd_a,
   output logic [OPW-1:0]   rd_b,
   output logic [3:0]       rd_mask,
   output logic [CW-1:0]    alloc_cnt,
   output logic             will_fill,
   output logic [CW-1:0]    cnt8,
   output logic [CW-1:0]    cnt16,
   output logic [CW-1:0]    cnt32
);
   logic [OPW-1:0]   mem_a [DEPTH];
   logic [OPW-1:0]   mem_b [DEPTH];
   logic [3:0]       mem_m [DEPTH];
   prec_e            mem_c [DEPTH];
   logic [DEPTH-1:0] pend_q;

   logic             open_q [3];
   logic [AW-1:0]    slot_q [3];
   logic [2:0]       lane_q [3];
   logic [CW-1:0]    cnt_q  [3];
   logic [CW-1:0]    alloc_q;

   logic [1:0]       ci;
   logic             opening;
   logic [AW-1:0]    tgt;
   logic [2:0]       lane;
   logic [2:0]       lane_nx;
   logic [2:0]       nlanes;
   logic [OPW-1:0]   keep;
   int unsigned      shamt;
   logic [OPW-1:0]   new_a, new_b;
   logic [3:0]       new_m;

   always_comb begin
      ci      = wr_cls;
      opening = wr_en && !open_q[ci];
      tgt     = opening ? alloc_q[AW-1:0] : slot_q[ci];
      lane    = opening ? 3'd0 : lane_q[ci];
      lane_nx = lane + 3'd1;
      nlanes  = 3'd4 >> ci;
      unique case (wr_cls)
         CLS_N32: begin keep = '1; shamt = 0; end
         CLS_N16: begin
            keep  = {{(2*SUBW){1'b0}}, {(2*SUBW){1'b1}}};
            shamt = 32'(lane) * 32'(2 * SUBW);
         end
         default: begin
            keep  = {{(3*SUBW){1'b0}}, {SUBW{1'b1}}};
            shamt = 32'(lane) * 32'(SUBW);
         end
      endcase
      new_a = (opening ? '0 : mem_a[tgt]) | ((wr_a & keep) << shamt);
      new_b = (opening ? '0 : mem_b[tgt]) | ((wr_b & keep) << shamt);
      new_m = (opening ? 4'd0 : mem_m[tgt]) | (4'd1 << lane);
      will_fill = opening && (alloc_q + CW'(1) == CW'(DEPTH));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         alloc_q <= '0;
         for (int k = 0; k < 3; k++) begin
            open_q[k] <= 1'b0;
            slot_q[k] <= '0;
            lane_q[k] <= '0;
            cnt_q[k]  <= '0;
         end
      end else if (clear) begin
         pend_q  <= '0;
         alloc_q <= '0;
         for (int k = 0; k < 3; k++) begin
            open_q[k] <= 1'b0;
            lane_q[k] <= '0;
            cnt_q[k]  <= '0;
         end
      end else begin
         if (pop_en)
            pend_q[pop_idx] <= 1'b0;
         if (wr_en) begin
            pend_q[tgt]  <= 1'b1;
            lane_q[ci]   <= lane_nx;
            open_q[ci]   <= (lane_nx != nlanes);
            if (opening) begin
               alloc_q    <= alloc_q + CW'(1);
               cnt_q[ci]  <= cnt_q[ci] + CW'(1);
               slot_q[ci] <= tgt;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) begin
         mem_a[tgt] <= new_a;
         mem_b[tgt] <= new_b;
         mem_m[tgt] <= new_m;
         mem_c[tgt] <= wr_cls;
      end
   end

   always_comb begin
      for (int i = 0; i < DEPTH; i++) begin
         pend_n8[i]  = pend_q[i] && (mem_c[i] == CLS_N8);
         pend_n16[i] = pend_q[i] && (mem_c[i] == CLS_N16);
         pend_n32[i] = pend_q[i] && (mem_c[i] == CLS_N32);
      end
   end

   assign rd_a      = mem_a[pop_idx];
   assign rd_b      = mem_b[pop_idx];
   assign rd_mask   = mem_m[pop_idx];
   assign alloc_cnt = alloc_q;
   assign cnt8      = cnt_q[0];
   assign cnt16     = cnt_q[1];
   assign cnt32     = cnt_q[2];
endmodule

// File: rtl/mps_pick.sv
module mps_pick
   import mps_pkg::*;
#(
   parameter int DEPTH = 60,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] pend_n8,
   input  logic [DEPTH-1:0] pend_n16,
   input  logic [DEPTH-1:0] pend_n32,
   output logic             any,
   output prec_e            pick_cls,
   output logic [AW-1:0]    pick_idx,
   output logic             last
);
   logic [DEPTH-1:0] vec;
   logic [DEPTH-1:0] rest;

   always_comb begin
      if (|pend_n8) begin
         vec = pend_n8;  pick_cls = CLS_N8;
      end else if (|pend_n16) begin
         vec = pend_n16; pick_cls = CLS_N16;
      end else begin
         vec = pend_n32; pick_cls = CLS_N32;
      end
      any      = |vec;
      pick_idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (vec[i]) pick_idx = AW'(i);
      rest = (pend_n8 | pend_n16 | pend_n32) & ~(DEPTH'(1) << pick_idx);
      last = any && !(|rest);
   end
endmodule

// File: rtl/mps_lut.sv
module mps_lut
   import mps_pkg::*;
#(
   parameter int VW     = 6,
   parameter int FW     = 4,
   parameter int F_CODE = 8,
   parameter int V_INIT = 63
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [1:0]    cfg_sel,
   input  logic [VW-1:0] cfg_volt,
   input  logic [FW-1:0] cfg_freq,
   input  prec_e         rd_cls,
   output logic [VW-1:0] rd_volt,
   output logic [FW-1:0] rd_freq
);
   logic [VW-1:0] volt_q [3];
   logic [FW-1:0] freq_q [3];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int g = 0; g < 3; g++) begin
            volt_q[g] <= VW'(V_INIT);
            freq_q[g] <= FW'(F_CODE >> (2 - g));
         end
      end else if (cfg_we) begin
         for (int g = 0; g < 3; g++) begin
            if (cfg_sel == 2'(g)) begin
               volt_q[g] <= cfg_volt;
               freq_q[g] <= cfg_freq;
            end
         end
      end
   end

   logic [1:0] ri;
   always_comb begin
      ri = rd_cls;
      if (ri == 2'd3) ri = 2'd2;
      rd_volt = volt_q[ri];
      rd_freq = freq_q[ri];
   end
endmodule

// File: rtl/mpsched_top.sv
module mpsched_top
   import mps_pkg::*;
#(
   parameter int SUBW   = 8,
   parameter int DEPTH  = 60,
   parameter int VW     = 6,
   parameter int FW     = 4,
   parameter int F_CODE = 8,
   parameter int V_INIT = 63,
   localparam int OPW   = 4 * SUBW,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   output logic           in_ready,
   input  logic [OPW-1:0] in_a,
   input  logic [OPW-1:0] in_b,
   input  logic           flush,
   output logic           out_valid,
   output logic [OPW-1:0] out_a,
   output logic [OPW-1:0] out_b,
   output logic [3:0]     out_mask,
   output logic [1:0]     out_mode,
   output logic [VW-1:0]  out_volt,
   output logic [FW-1:0]  out_freq,
   output logic [CW-1:0]  n8_cnt,
   output logic [CW-1:0]  n16_cnt,
   output logic [CW-1:0]  n32_cnt,
   input  logic           cfg_we,
   input  logic [1:0]     cfg_sel,
   input  logic [VW-1:0]  cfg_volt,
   input  logic [FW-1:0]  cfg_freq
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("mpsched_top: DEPTH must be at least 2");
   end
   if (SUBW < 1) begin : g_bad_subw
      $error("mpsched_top: SUBW must be positive");
   end
   if (F_CODE >= (1 << FW) || V_INIT >= (1 << VW)) begin : g_bad_init
      $error("mpsched_top: table reset codes exceed field widths");
   end

   phase_e           phase_q;
   prec_e            in_cls;
   prec_e            pick_cls;
   logic             accept, close_fill, pop_en, clear;
   logic [DEPTH-1:0] p8, p16, p32;
   logic             any, last, will_fill;
   logic [AW-1:0]    pick_idx;
   logic [CW-1:0]    alloc_cnt;

   mps_classify #(.SUBW(SUBW)) u_cls (
      .opa (in_a),
      .opb (in_b),
      .cls (in_cls)
   );

   mps_store #(.SUBW(SUBW), .DEPTH(DEPTH)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (accept),
      .wr_cls    (in_cls),
      .wr_a      (in_a),
      .wr_b      (in_b),
      .pop_en    (pop_en),
      .pop_idx   (pick_idx),
      .clear     (clear),
      .pend_n8   (p8),
      .pend_n16  (p16),
      .pend_n32  (p32),
      .rd_a      (out_a),
      .rd_b      (out_b),
      .rd_mask   (out_mask),
      .alloc_cnt (alloc_cnt),
      .will_fill (will_fill),
      .cnt8      (n8_cnt),
      .cnt16     (n16_cnt),
      .cnt32     (n32_cnt)
   );

   mps_pick #(.DEPTH(DEPTH)) u_pick (
      .pend_n8  (p8),
      .pend_n16 (p16),
      .pend_n32 (p32),
      .any      (any),
      .pick_cls (pick_cls),
      .pick_idx (pick_idx),
      .last     (last)
   );

   mps_lut #(.VW(VW), .FW(FW), .F_CODE(F_CODE), .V_INIT(V_INIT)) u_lut (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_we   (cfg_we),
      .cfg_sel  (cfg_sel),
      .cfg_volt (cfg_volt),
      .cfg_freq (cfg_freq),
      .rd_cls   (pick_cls),
      .rd_volt  (out_volt),
      .rd_freq  (out_freq)
   );

   always_comb begin
      in_ready   = (phase_q == PH_FILL);
      accept     = in_valid && in_ready;
      close_fill = in_ready &&
                   ((accept && will_fill) ||
                    (flush && ((alloc_cnt != '0) || accept)));
      pop_en     = (phase_q == PH_DRAIN) && any;
      clear      = (phase_q == PH_DRAIN) && (last || !any);
      out_valid  = pop_en;
      out_mode   = pick_cls;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         phase_q <= PH_FILL;
      else if (close_fill)
         phase_q <= PH_DRAIN;
      else if (clear)
         phase_q <= PH_FILL;
   end
endmodule

// File: rtl/mps_checker.sv
module mps_checker #(
   parameter int DEPTH = 60,
   parameter int CW    = 6
) (
   input logic          clk,
   input logic          rst_n,
   input logic          in_valid,
   input logic          in_ready,
   input logic          flush,
   input logic          out_valid,
   input logic [3:0]    out_mask,
   input logic [1:0]    out_mode,
   input logic [CW-1:0] n8_cnt,
   input logic [CW-1:0] n16_cnt,
   input logic [CW-1:0] n32_cnt
);
   logic [CW+1:0] tot;
   logic          none;
   assign tot  = (CW+2)'(n8_cnt) + (CW+2)'(n16_cnt) + (CW+2)'(n32_cnt);
   assign none = (tot == '0);

   AST_DRAIN_STALL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !in_ready); // R7

   AST_CLASS_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && $past(out_valid)) |-> (out_mode >= $past(out_mode))); // R6

   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_mode != 2'd3)); // R1

   AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_mask[0] && (out_mode != 2'd2 || out_mask[3:1] == 3'd0)
                     && (out_mode != 2'd1 || out_mask[3:2] == 2'd0))); // R3

   AST_LANE_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_mask inside {4'b0001, 4'b0011, 4'b0111, 4'b1111})); // R2

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      tot <= (CW+2)'(DEPTH)); // R4

   AST_EMPTY_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ready && flush && !in_valid && none) |=> (in_ready && !out_valid)); // R5

   AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ready) |-> none); // R8
endmodule

bind mpsched_top mps_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .flush     (flush),
   .out_valid (out_valid),
   .out_mask  (out_mask),
   .out_mode  (out_mode),
   .n8_cnt    (n8_cnt),
   .n16_cnt   (n16_cnt),
   .n32_cnt   (n32_cnt)
);

// File: tb/mpsched_top_tb.sv
`timescale 1ns/1ps
module mpsched_top_tb;
   localparam int DEPTH = 60;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_a = '0, in_b = '0;
   logic        flush = 1'b0;
   logic        out_valid;
   logic [31:0] out_a, out_b;
   logic [3:0]  out_mask;
   logic [1:0]  out_mode;
   logic [5:0]  out_volt;
   logic [3:0]  out_freq;
   logic [5:0]  n8_cnt, n16_cnt, n32_cnt;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic [5:0]  cfg_volt = '0;
   logic [3:0]  cfg_freq = '0;

   always #2 clk = ~clk;

   mpsched_top u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_a(in_a), .in_b(in_b), .flush(flush), .out_valid(out_valid),
      .out_a(out_a), .out_b(out_b), .out_mask(out_mask), .out_mode(out_mode),
      .out_volt(out_volt), .out_freq(out_freq), .n8_cnt(n8_cnt),
      .n16_cnt(n16_cnt), .n32_cnt(n32_cnt), .cfg_we(cfg_we),
      .cfg_sel(cfg_sel), .cfg_volt(cfg_volt), .cfg_freq(cfg_freq)
   );

   int checks = 0, errors = 0;
   bit done = 0;

   // model state
   int          m_alloc;
   bit          m_open [3];
   int          m_slot [3];
   int          m_lane [3];
   int          m_cnt  [3];
   logic [31:0] ma [DEPTH];
   logic [31:0] mb [DEPTH];
   logic [3:0]  mm [DEPTH];
   int          mc [DEPTH];
   logic [5:0]  lv [3];
   logic [3:0]  lf [3];
   string       set_tag = "R9";

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
      end
   endtask

   function automatic int cls_of(input logic [31:0] v);
      if (v[31:16] != 0) return 2;
      if (v[15:8] != 0) return 1;
      return 0;
   endfunction

   function automatic void m_reset();
      m_alloc = 0;
      for (int k = 0; k < 3; k++) begin
         m_open[k] = 0; m_lane[k] = 0; m_cnt[k] = 0; m_slot[k] = 0;
      end
   endfunction

   function automatic void m_push(input logic [31:0] a, input logic [31:0] b);
      int c, w, s;
      logic [63:0] lm;
      c  = (cls_of(a) > cls_of(b)) ? cls_of(a) : cls_of(b);
      w  = 8 << c;
      lm = (64'd1 << w) - 64'd1;
      if (!m_open[c]) begin
         s = m_alloc; m_alloc++;
         ma[s] = '0; mb[s] = '0; mm[s] = '0; mc[s] = c;
         m_slot[c] = s; m_lane[c] = 0; m_cnt[c]++;
      end
      s = m_slot[c];
      ma[s] = ma[s] | 32'((64'(a) & lm) << (m_lane[c] * w));
      mb[s] = mb[s] | 32'((64'(b) & lm) << (m_lane[c] * w));
      mm[s][m_lane[c]] = 1'b1;
      m_lane[c]++;
      m_open[c] = (m_lane[c] < (4 >> c));
   endfunction

   task automatic send(input logic [31:0] a, input logic [31:0] b, input bit fl);
      @(negedge clk);
      chk(in_ready == 1'b1, "R4", "ready while filling", 64'(in_ready), 64'd1);
      in_a = a; in_b = b; in_valid = 1'b1; flush = fl;
      @(posedge clk);
      #1 in_valid = 1'b0; flush = 1'b0;
      m_push(a, b);
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(posedge clk);
      #1 flush = 1'b0;
   endtask

   task automatic drain_check(input string mtag);
      int ord [DEPTH];
      int n = 0;
      for (int c = 0; c < 3; c++)
         for (int s = 0; s < m_alloc; s++)
            if (mc[s] == c) begin ord[n] = s; n++; end
      for (int i = 0; i < n; i++) begin
         int s = ord[i];
         @(negedge clk);
         if (i == 0) begin
            chk(n8_cnt == 6'(m_cnt[0]), "R8", "n8 count", 64'(n8_cnt), 64'(m_cnt[0]));
            chk(n16_cnt == 6'(m_cnt[1]), "R8", "n16 count", 64'(n16_cnt), 64'(m_cnt[1]));
            chk(n32_cnt == 6'(m_cnt[2]), "R8", "n32 count", 64'(n32_cnt), 64'(m_cnt[2]));
         end
         chk(out_valid == 1'b1, "R6", "valid each drain cycle", 64'(out_valid), 64'd1);
         chk(in_ready == 1'b0, "R7", "stall in drain", 64'(in_ready), 64'd0);
         chk(out_mode == 2'(mc[s]), mtag, "mode", 64'(out_mode), 64'(mc[s]));
         chk(out_a == ma[s], "R2", "lanes a", 64'(out_a), 64'(ma[s]));
         chk(out_b == mb[s], "R2", "lanes b", 64'(out_b), 64'(mb[s]));
         chk(out_mask == mm[s], "R3", "mask", 64'(out_mask), 64'(mm[s]));
         chk({out_volt, out_freq} == {lv[mc[s]], lf[mc[s]]}, set_tag, "setting",
             64'({out_volt, out_freq}), 64'({lv[mc[s]], lf[mc[s]]}));
      end
      @(negedge clk);
      chk(out_valid == 1'b0, "R7", "drain over", 64'(out_valid), 64'd0);
      chk(in_ready == 1'b1, "R7", "ready after drain", 64'(in_ready), 64'd1);
      chk({n8_cnt, n16_cnt, n32_cnt} == 18'd0, "R8", "counts cleared",
          64'({n8_cnt, n16_cnt, n32_cnt}), 64'd0);
      m_reset();
   endtask

   task automatic lut_write(input logic [1:0] sel, input logic [5:0] v, input logic [3:0] f);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = sel; cfg_volt = v; cfg_freq = f;
      @(posedge clk);
      #1 cfg_we = 1'b0;
      if (sel != 2'd3) begin lv[sel] = v; lf[sel] = f; end
   endtask

   function automatic logic [31:0] rnd_op();
      unique case ($urandom % 4)
         0: return 32'd0;
         1: return $urandom & 32'hFF;
         2: return ($urandom & 32'hFFFF) | 32'h100;
         default: return $urandom | 32'h10000;
      endcase
   endfunction

   task automatic random_fill();
      while (m_alloc < DEPTH)
         send(rnd_op(), rnd_op(), 1'b0);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4711));
      m_reset();
      for (int k = 0; k < 3; k++) begin
         lv[k] = 6'd63; lf[k] = 4'(8 >> (2 - k));
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R11 reset state
      @(negedge clk);
      chk(in_ready == 1'b1, "R11", "ready after reset", 64'(in_ready), 64'd1);
      chk(out_valid == 1'b0, "R11", "idle after reset", 64'(out_valid), 64'd0);
      chk({n8_cnt, n16_cnt, n32_cnt} == 18'd0, "R11", "counts after reset",
          64'({n8_cnt, n16_cnt, n32_cnt}), 64'd0);

      // R5 flush on empty buffer
      do_flush();
      @(negedge clk);
      chk(out_valid == 1'b0, "R5", "empty flush no output", 64'(out_valid), 64'd0);
      chk(in_ready == 1'b1, "R5", "empty flush stays ready", 64'(in_ready), 64'd1);

      // R1 class boundaries, padded lanes, default table (R9)
      send(32'h0, 32'h0, 1'b0);
      send(32'hFF, 32'h1, 1'b0);
      send(32'h100, 32'h1, 1'b0);
      send(32'h10000, 32'h5, 1'b0);
      send(32'h3, 32'hFFFF, 1'b0);
      send(32'h7, 32'h7, 1'b0);
      do_flush();
      drain_check("R1");

      // R10 table writes, sel 3 ignored
      lut_write(2'd1, 6'd20, 4'd5);
      lut_write(2'd3, 6'd1, 4'd1);
      lut_write(2'd0, 6'd10, 4'd3);
      lut_write(2'd2, 6'd40, 4'd9);
      set_tag = "R10";

      // R4 full buffer, R6 ordering
      random_fill();
      drain_check("R6");

      // R5 flush together with an accept, mid fill
      for (int i = 0; i < 17; i++) send(rnd_op(), rnd_op(), 1'b0);
      send(32'h1234_5678, 32'h9, 1'b1);
      drain_check("R6");

      // another full fill, narrow-heavy
      while (m_alloc < DEPTH)
         send($urandom & 32'hFF, ($urandom % 3 == 0) ? rnd_op() : 32'h3, 1'b0);
      drain_check("R6");

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule